// File: doc/BRIEF.md
# Multi-Mode Transport Stream Input Receiver

This block is the front end of a transport stream receive path. It samples a demodulator-style port (a sync strobe, a valid strobe and an 8-bit data bus) in the port's own clock domain and turns it into a byte stream. Each output byte carries a flag that marks the first byte of a packet. Downstream logic handles packet alignment, filtering and any crossing into another clock domain.

A 2-bit mode input selects one of four framing disciplines. In the bit-serial mode the block gathers eight qualified bits into a byte, in an order chosen by a configuration bit. In the two strobed byte-parallel modes every qualified cycle carries one byte. In the burst mode a single sync pulse stands for a whole packet, whose remaining bytes follow on consecutive cycles without any valid strobe. When the mode input changes, all partially gathered state is thrown away.

Top module: `ts_rx_frontend`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it rises, byte_valid_o, byte_start_o, burst_err_o and byte_data_o are all zero.
- R2: In mode 2'b01, each cycle with valid_i high yields one byte on the next cycle, with byte_data_o equal to data_i and byte_start_o equal to sync_i. A cycle with valid_i low yields no byte, whatever sync_i is.
- R3: In mode 2'b11, each cycle with valid_i high yields one byte carrying data_i, and byte_start_o stays low. sync_i has no effect.
- R4: In mode 2'b00, the serial bit is data_i[0], and it is taken only on cycles with valid_i high. A qualified bit with sync_i high is bit 0 of a new byte. A byte is emitted on the cycle after every eighth qualified bit counted from the last emitted byte or the last sync. byte_start_o is set on the first byte completed after a sync. sync_i without valid_i is ignored.
- R5: In mode 2'b00 with lsb_first_i low, the first bit of a byte lands in byte_data_o[7]. With lsb_first_i high it lands in byte_data_o[0].
- R6: In mode 2'b10, sync_i high yields a start byte on the next cycle, and each of the following PKT_BYTES-1 (187) cycles yields one byte carrying data_i, whatever valid_i is. Outside a burst, cycles without sync_i yield nothing.
- R7: In mode 2'b10, a sync_i while burst bytes are still due yields a start byte with burst_err_o high for that one cycle, and the byte count restarts from that sync.
- R8: On a cycle where mode_i differs from its value on the previous cycle, no byte is produced, and the partial serial byte, the pending start flag and any remaining burst count are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input stream clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Framing mode: 00 serial, 01 parallel strobed, 10 burst, 11 valid only |
| lsb_first_i | input | 1 | Serial bit order: 1 puts the first bit in bit 0 |
| sync_i | input | 1 | Packet start strobe |
| valid_i | input | 1 | Data qualifier |
| data_i | input | 8 | Parallel byte; bit 0 is the serial line |
| byte_valid_o | output | 1 | Output byte present |
| byte_start_o | output | 1 | Output byte is a packet's first byte |
| byte_data_o | output | 8 | Output byte |
| burst_err_o | output | 1 | Sync arrived during a burst (one-cycle pulse) |

## Verification
The hardest situations to reach are those where state left over from earlier traffic must be discarded: a sync that lands partway through a serial byte, a sync inside an unfinished burst, and a mode switch that interrupts partial serial bits or a running burst. The bench reaches each one by running a full packet or byte pattern and then placing the disturbing event at a chosen cycle. It then checks that the next emitted byte contains only bits sent after the event, and that no stray burst bytes follow it. Serial behaviour is swept across both bit orders with stall cycles interleaved, and the burst is followed byte by byte to its end.

// File: rtl/ts_rx_pkg.sv
package ts_rx_pkg;
  typedef enum logic [1:0] {
    MODE_SER_SV    = 2'b00,
    MODE_PAR_SV    = 2'b01,
    MODE_PAR_BURST = 2'b10,
    MODE_PAR_VONLY = 2'b11
  } rx_mode_e;
endpackage

// File: rtl/ts_rx_serdes.sv
module ts_rx_serdes (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       clear_i,
  input  logic       lsb_first_i,
  input  logic       sync_i,
  input  logic       valid_i,
  input  logic       bit_i,
  output logic       emit_o,
  output logic       start_o,
  output logic [7:0] byte_o
);
  logic [7:0] acc_q, acc_d;
  logic [2:0] cnt_q, cnt_d;
  logic       sop_q, sop_d;
  logic [2:0] base_cnt;
  logic       pend;

  always_comb begin
    acc_d    = acc_q;
    cnt_d    = cnt_q;
    sop_d    = sop_q;
    emit_o   = 1'b0;
    start_o  = 1'b0;
    base_cnt = sync_i ? 3'd0 : cnt_q;
    pend     = sync_i | sop_q;
    if (clear_i) begin
      acc_d = '0;
      cnt_d = '0;
      sop_d = 1'b0;
    end else if (en_i && valid_i) begin
      acc_d = lsb_first_i ? {bit_i, acc_q[7:1]} : {acc_q[6:0], bit_i};
      if (base_cnt == 3'd7) begin
        emit_o  = 1'b1;
        start_o = pend;
        cnt_d   = '0;
        sop_d   = 1'b0;
      end else begin
        cnt_d = base_cnt + 3'd1;
        sop_d = pend;
      end
    end
  end

  assign byte_o = acc_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cnt_q <= '0;
      sop_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
      sop_q <= sop_d;
    end
  end

  AST_SER_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emit_o |=> (cnt_q == 3'd0 && !sop_q)); // R4
endmodule

// File: rtl/ts_rx_burst.sv
module ts_rx_burst #(
  parameter int PKT_BYTES = 188,
  localparam int CNT_W = $clog2(PKT_BYTES)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clear_i,
  input  logic sync_i,
  output logic beat_o,
  output logic start_o,
  output logic err_o
);
  localparam logic [CNT_W-1:0] REM_INIT = CNT_W'(PKT_BYTES - 1);

  logic [CNT_W-1:0] rem_q, rem_d;

  always_comb begin
    rem_d   = rem_q;
    beat_o  = 1'b0;
    start_o = 1'b0;
    err_o   = 1'b0;
    if (clear_i) begin
      rem_d = '0;
    end else if (en_i) begin
      if (sync_i) begin
        beat_o  = 1'b1;
        start_o = 1'b1;
        err_o   = (rem_q != '0);
        rem_d   = REM_INIT;
      end else if (rem_q != '0) begin
        beat_o = 1'b1;
        rem_d  = rem_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rem_q <= '0;
    else         rem_q <= rem_d;
  end

  AST_BURST_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_q <= REM_INIT); // R6
  AST_BURST_COUNTDOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clear_i && !sync_i && rem_q > 1) |=> rem_q != '0); // R6
endmodule

// File: rtl/ts_rx_frontend.sv
module ts_rx_frontend
  import ts_rx_pkg::*;
#(
  parameter int PKT_BYTES = 188
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       lsb_first_i,
  input  logic       sync_i,
  input  logic       valid_i,
  input  logic [7:0] data_i,
  output logic       byte_valid_o,
  output logic       byte_start_o,
  output logic [7:0] byte_data_o,
  output logic       burst_err_o
);
  rx_mode_e mode, mode_q;
  logic     clear;

  assign mode  = rx_mode_e'(mode_i);
  assign clear = (mode != mode_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_SER_SV;
    else         mode_q <= mode;
  end

  logic       ser_emit, ser_start;
  logic [7:0] ser_byte;

  ts_rx_serdes i_serdes (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (mode == MODE_SER_SV),
    .clear_i     (clear),
    .lsb_first_i (lsb_first_i),
    .sync_i      (sync_i),
    .valid_i     (valid_i),
    .bit_i       (data_i[0]),
    .emit_o      (ser_emit),
    .start_o     (ser_start),
    .byte_o      (ser_byte)
  );

  logic bst_beat, bst_start, bst_err;

  ts_rx_burst #(.PKT_BYTES(PKT_BYTES)) i_burst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (mode == MODE_PAR_BURST),
    .clear_i (clear),
    .sync_i  (sync_i),
    .beat_o  (bst_beat),
    .start_o (bst_start),
    .err_o   (bst_err)
  );

  logic       vld_d, sop_d, err_d;
  logic [7:0] dat_d;

  always_comb begin
    vld_d = 1'b0;
    sop_d = 1'b0;
    err_d = 1'b0;
    dat_d = data_i;
    if (!clear) begin
      unique case (mode)
        MODE_SER_SV: begin
          vld_d = ser_emit;
          sop_d = ser_start;
          dat_d = ser_byte;
        end
        MODE_PAR_SV: begin
          vld_d = valid_i;
          sop_d = valid_i & sync_i;
        end
        MODE_PAR_BURST: begin
          vld_d = bst_beat;
          sop_d = bst_start;
          err_d = bst_err;
        end
        default: begin
          vld_d = valid_i;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_valid_o <= 1'b0;
      byte_start_o <= 1'b0;
      byte_data_o  <= '0;
      burst_err_o  <= 1'b0;
    end else begin
      byte_valid_o <= vld_d;
      byte_start_o <= sop_d;
      byte_data_o  <= vld_d ? dat_d : byte_data_o;
      burst_err_o  <= err_d;
    end
  end

  AST_START_HAS_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_start_o |-> byte_valid_o); // R2
  AST_VONLY_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_start_o |-> ($past(mode_i) != 2'b11)); // R3
  AST_ERR_WITH_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_err_o |-> (byte_start_o && $past(mode_i) == 2'b10)); // R7
  AST_STROBED_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_o && $past(mode_i) != 2'b10) |-> $past(valid_i)); // R2
endmodule

// File: tb/test_ts_rx_frontend.sv
module test_ts_rx_frontend;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       lsb = 1'b0;
  logic       sync = 1'b0;
  logic       valid = 1'b0;
  logic [7:0] data = '0;
  logic       b_vld, b_sop, b_err;
  logic [7:0] b_dat;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ts_rx_frontend i_ts_rx_frontend (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .lsb_first_i(lsb),
    .sync_i(sync), .valid_i(valid), .data_i(data),
    .byte_valid_o(b_vld), .byte_start_o(b_sop), .byte_data_o(b_dat),
    .burst_err_o(b_err)
  );

  task automatic chk(input string req, input logic ev, input logic es, input logic ee,
                     input logic [7:0] ed);
    checks++;
    if (b_vld !== ev || b_sop !== es || b_err !== ee || (ev && b_dat !== ed)) begin
      fails++;
      $display("FAIL %s: got v=%b s=%b e=%b d=%h, expected v=%b s=%b e=%b d=%h",
               req, b_vld, b_sop, b_err, b_dat, ev, es, ee, ed);
    end
  endtask

  // drive after a falling edge, result visible at the next falling edge
  task automatic step(input logic s, input logic v, input logic [7:0] d, input string req,
                      input logic ev, input logic es, input logic ee, input logic [7:0] ed);
    sync = s; valid = v; data = d;
    @(negedge clk);
    chk(req, ev, es, ee, ed);
  endtask

  task automatic ser_byte(input logic [7:0] b, input logic with_sync, input logic exp_sop,
                          input logic stall);
    for (int i = 0; i < 8; i++) begin
      logic bt;
      bt = lsb ? b[i] : b[7-i];
      step(with_sync && i == 0, 1'b1, {7'b0, bt}, "R4", i == 7, exp_sop && i == 7, 1'b0, b);
      if (stall && i == 3) step(1'b1, 1'b0, 8'h01, "R4", 1'b0, 1'b0, 1'b0, 8'h00);
    end
  endtask

  task automatic set_mode(input logic [1:0] m);
    mode = m;
    step(1'b0, 1'b1, 8'hFF, "R8", 1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", 1'b0, 1'b0, 1'b0, 8'h00);
    checks++;
    if (b_dat !== 8'h00) begin
      fails++;
      $display("FAIL R1: got data %h, expected 00", b_dat);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 1'b0, 1'b0, 1'b0, 8'h00);

    // R2 parallel strobed
    set_mode(2'b01);
    for (int k = 0; k < 40; k++) begin
      logic s, v;
      s = (k % 10 == 0) || (k % 7 == 3);
      v = (k % 4 != 2);
      step(s, v, 8'(k * 29 + 3), "R2", v, s & v, 1'b0, 8'(k * 29 + 3));
    end

    // R3 valid only, sync ignored
    set_mode(2'b11);
    for (int k = 0; k < 40; k++) begin
      logic v;
      v = (k % 3 != 1);
      step(k[0], v, 8'(k * 53 + 7), "R3", v, 1'b0, 1'b0, 8'(k * 53 + 7));
    end

    // R4/R5 serial sweep, both orders
    set_mode(2'b00);
    for (int o = 0; o < 2; o++) begin
      lsb = o[0];
      for (int k = 0; k < 24; k++)
        ser_byte(8'(k * 37 + o * 5 + 1), k == 0 || k == 11, k == 0 || k == 11, k % 3 == 0);
    end
    // R5 explicit orientation: single high first bit
    lsb = 1'b0; ser_byte(8'h80, 1'b1, 1'b1, 1'b0);
    lsb = 1'b1; ser_byte(8'h01, 1'b1, 1'b1, 1'b0);

    // R4 sync mid-byte restarts the bit count
    lsb = 1'b0;
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 8'h01, "R4", 1'b0, 1'b0, 1'b0, 8'h00);
    ser_byte(8'hA5, 1'b1, 1'b1, 1'b0);

    // R8 mode change drops partial serial bits and pending start
    step(1'b1, 1'b1, 8'h01, "R8", 1'b0, 1'b0, 1'b0, 8'h00);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 8'h01, "R8", 1'b0, 1'b0, 1'b0, 8'h00);
    mode = 2'b01;
    step(1'b1, 1'b1, 8'h33, "R8", 1'b0, 1'b0, 1'b0, 8'h00);
    mode = 2'b00;
    step(1'b0, 1'b1, 8'h01, "R8", 1'b0, 1'b0, 1'b0, 8'h00);
    ser_byte(8'h5C, 1'b0, 1'b0, 1'b0);

    // R6 burst: valid ignored, idle produces nothing
    set_mode(2'b10);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 8'h11, "R6", 1'b0, 1'b0, 1'b0, 8'h00);
    step(1'b1, 1'b0, 8'hC3, "R6", 1'b1, 1'b1, 1'b0, 8'hC3);
    for (int k = 1; k < 188; k++)
      step(1'b0, k[2], 8'(k ^ 8'h5A), "R6", 1'b1, 1'b0, 1'b0, 8'(k ^ 8'h5A));
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 8'h22, "R6", 1'b0, 1'b0, 1'b0, 8'h00);

    // R7 sync inside burst restarts the count
    step(1'b1, 1'b0, 8'h47, "R7", 1'b1, 1'b1, 1'b0, 8'h47);
    for (int k = 1; k < 50; k++) step(1'b0, 1'b0, 8'(k), "R7", 1'b1, 1'b0, 1'b0, 8'(k));
    step(1'b1, 1'b0, 8'h48, "R7", 1'b1, 1'b1, 1'b1, 8'h48);
    for (int k = 1; k < 188; k++) step(1'b0, 1'b0, 8'(k + 9), "R7", 1'b1, 1'b0, 1'b0, 8'(k + 9));
    step(1'b0, 1'b0, 8'h00, "R7", 1'b0, 1'b0, 1'b0, 8'h00);
    // sync right after a burst ends is not an error
    step(1'b1, 1'b0, 8'h49, "R7", 1'b1, 1'b1, 1'b0, 8'h49);

    // R8 mode change abandons the running burst
    for (int k = 1; k < 10; k++) step(1'b0, 1'b0, 8'(k), "R8", 1'b1, 1'b0, 1'b0, 8'(k));
    mode = 2'b11;
    step(1'b0, 1'b0, 8'h66, "R8", 1'b0, 1'b0, 1'b0, 8'h00);
    mode = 2'b10;
    step(1'b0, 1'b0, 8'h67, "R8", 1'b0, 1'b0, 1'b0, 8'h00);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 8'h68, "R8", 1'b0, 1'b0, 1'b0, 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule